// File: doc/BRIEF.md
# Random Generator Command Guard

This block sits beside the command path of a deterministic random bit generator and watches for faults that software can recover from. Each cycle it looks at a command header (when its valid strobe is high), at three multi-bit boolean fields taken from a configuration register, and at the generator's output data bus (when its valid strobe is high). Every fault kind has its own sticky status bit. A single alert line is raised whenever any status bit is set.

Multi-bit booleans are four bits wide: 0x6 means true, 0x9 means false, and every other value is invalid. The command header is 25 bits wide. The command code sits in bits [3:0], the additional-data length in [7:4], the flag in [11:8] and the generate length in [24:12]. Legal command codes are 1 (instantiate), 2 (reseed), 3 (generate), 4 (update) and 5 (uninstantiate).

Software clears status through a register write. Each status bit survives only where the written word holds a one, so writing all zeros clears every bit.

Top module: `drbg_cmd_guard`

## Requirements
- R1: A header accepted with cmd_vld_i high and a code of 0x0 or 0x6..0xF sets sts_o[4] on the next clock edge. Codes 0x1..0x5 do not set it.
- R2: Configuration field k (cfg_i[4k+3:4k], k = 0..2) holding any value other than 0x6 or 0x9 sets sts_o[k] on the next edge. Each field is judged on its own.
- R3: A valid header with code 0x1 or 0x2 whose flag (bits [11:8]) is not 0x6 or 0x9 sets sts_o[3]. For other codes the flag is ignored.
- R4: A word taken with out_vld_i high that equals the previous word taken with out_vld_i high sets sts_o[5]. Data present while out_vld_i is low is neither compared nor stored. The first word after reset is never flagged, even if it is zero.
- R5: alert_o is high exactly when sts_o is non-zero.
- R6: A write (sts_we_i high) keeps each status bit only where sts_wdata_i has a one. Writing zero clears all six bits.
- R7: Status bits are sticky: once set, a bit stays set until a write clears it, even after the fault condition goes away.
- R8: When a fault condition and a clearing write fall in the same cycle, the faulting bit ends up set.
- R9: After reset, sts_o is zero and alert_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_vld_i | input | 1 | Command header valid |
| cmd_hdr_i | input | 25 | Command header word |
| cfg_i | input | 12 | Three 4-bit multi-bit boolean configuration fields |
| out_vld_i | input | 1 | Output data word valid |
| out_data_i | input | 32 | Output data word |
| sts_we_i | input | 1 | Status register write enable |
| sts_wdata_i | input | 6 | Status write data (keep mask) |
| sts_o | output | 6 | Sticky status bits |
| alert_o | output | 1 | Recoverable alert summary |

## Verification
The status write and the fault detectors can act on the same clock edge, so a clear may coincide with a new fault. The bench provokes this by driving an all-zero write in the same cycle as an illegal command code. It then judges the outcome by checking that only the command bit survives.

A second collision is a partial clear: a write mask keeps one bit while dropping another, and each bit's outcome is compared with the mask.

// File: rtl/drbg_guard_pkg.sv
package drbg_guard_pkg;

    parameter int MB_W   = 4;
    parameter int CODE_W = 4;
    parameter int CLEN_W = 4;
    parameter int GLEN_W = 13;
    parameter int HDR_W  = CODE_W + CLEN_W + MB_W + GLEN_W;

    parameter logic [MB_W-1:0] MB_TRUE  = 4'h6;
    parameter logic [MB_W-1:0] MB_FALSE = 4'h9;

    parameter logic [CODE_W-1:0] OP_INST   = 4'd1;
    parameter logic [CODE_W-1:0] OP_RESEED = 4'd2;
    parameter logic [CODE_W-1:0] OP_LAST   = 4'd5;

    parameter int NUM_CFG = 3;
    parameter int ST_FLAG = NUM_CFG;
    parameter int ST_CMD  = NUM_CFG + 1;
    parameter int ST_REP  = NUM_CFG + 2;
    parameter int STS_W   = NUM_CFG + 3;

    typedef struct packed {
        logic [GLEN_W-1:0] glen;
        logic [MB_W-1:0]   flag;
        logic [CLEN_W-1:0] clen;
        logic [CODE_W-1:0] code;
    } hdr_t;

endpackage

// File: rtl/drbg_guard_mubi.sv
module drbg_guard_mubi
    import drbg_guard_pkg::*;
(
    input  logic [MB_W-1:0] val_i,
    output logic            bad_o
);
    always_comb begin
        bad_o = !((val_i == MB_TRUE) || (val_i == MB_FALSE));
    end
endmodule

// File: rtl/drbg_guard_cmd.sv
module drbg_guard_cmd
    import drbg_guard_pkg::*;
(
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [MB_W-1:0]   flag_i,
    output logic              bad_code_o,
    output logic              bad_flag_o
);
    logic flag_bad;
    logic seeds;

    drbg_guard_mubi u_flag (
        .val_i (flag_i),
        .bad_o (flag_bad)
    );

    always_comb begin
        seeds      = (code_i == OP_INST) || (code_i == OP_RESEED);
        bad_code_o = vld_i && ((code_i == '0) || (code_i > OP_LAST));
        bad_flag_o = vld_i && seeds && flag_bad;
    end
endmodule

// File: rtl/drbg_guard_repeat.sv
module drbg_guard_repeat #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o
);
    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic              seen;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d = rep_q;
        hit_o = 1'b0;
        if (vld_i) begin
            hit_o      = rep_q.seen && (data_i == rep_q.prev);
            rep_d.prev = data_i;
            rep_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rep_q <= '0;
        else         rep_q <= rep_d;
    end
endmodule

// File: rtl/drbg_cmd_guard.sv
module drbg_cmd_guard
    import drbg_guard_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cmd_vld_i,
    input  logic [HDR_W-1:0]        cmd_hdr_i,
    input  logic [NUM_CFG*MB_W-1:0] cfg_i,
    input  logic                    out_vld_i,
    input  logic [DATA_W-1:0]       out_data_i,
    input  logic                    sts_we_i,
    input  logic [STS_W-1:0]        sts_wdata_i,
    output logic [STS_W-1:0]        sts_o,
    output logic                    alert_o
);
    typedef struct packed {
        logic [STS_W-1:0] sts;
    } guard_t;

    guard_t g_d, g_q;
    hdr_t   hdr;
    logic [NUM_CFG-1:0] cfg_bad;
    logic [STS_W-1:0]   set_vec;
    logic bad_code, bad_flag, rep_hit;
    logic unused_hdr;

    assign hdr        = cmd_hdr_i;
    assign unused_hdr = ^{hdr.clen, hdr.glen};

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        drbg_guard_mubi u_mb (
            .val_i (cfg_i[k*MB_W +: MB_W]),
            .bad_o (cfg_bad[k])
        );
    end

    drbg_guard_cmd u_cmd (
        .vld_i      (cmd_vld_i),
        .code_i     (hdr.code),
        .flag_i     (hdr.flag),
        .bad_code_o (bad_code),
        .bad_flag_o (bad_flag)
    );

    drbg_guard_repeat #(.DATA_W(DATA_W)) u_rep (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (out_vld_i),
        .data_i (out_data_i),
        .hit_o  (rep_hit)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[NUM_CFG-1:0]   = cfg_bad;
        set_vec[ST_FLAG]       = bad_flag;
        set_vec[ST_CMD]        = bad_code;
        set_vec[ST_REP]        = rep_hit;
        g_d = g_q;
        if (sts_we_i) g_d.sts = g_q.sts & sts_wdata_i;
        g_d.sts = g_d.sts | set_vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign sts_o   = g_q.sts;
    assign alert_o = |g_q.sts;
endmodule

// File: rtl/drbg_cmd_guard_chk.sv
module drbg_cmd_guard_chk
    import drbg_guard_pkg::*;
(
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    cmd_vld_i,
    input logic [HDR_W-1:0]        cmd_hdr_i,
    input logic [NUM_CFG*MB_W-1:0] cfg_i,
    input logic                    out_vld_i,
    input logic                    sts_we_i,
    input logic [STS_W-1:0]        sts_wdata_i,
    input logic [STS_W-1:0]        sts_o,
    input logic                    alert_o
);
    function automatic logic mb_ok(logic [MB_W-1:0] v);
        return (v == MB_TRUE) || (v == MB_FALSE);
    endfunction

    logic [CODE_W-1:0] code;
    logic [MB_W-1:0]   flag;
    logic              cfg_all_ok;
    logic              unused_bits;

    assign code        = cmd_hdr_i[CODE_W-1:0];
    assign flag        = cmd_hdr_i[CODE_W+CLEN_W +: MB_W];
    assign unused_bits = ^{cmd_hdr_i[HDR_W-1:CODE_W+CLEN_W+MB_W], cmd_hdr_i[CODE_W +: CLEN_W]};
    assign cfg_all_ok  = mb_ok(cfg_i[3:0]) && mb_ok(cfg_i[7:4]) && mb_ok(cfg_i[11:8]);

    AST_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && (code == 4'd0 || code > 4'd5)) |=> sts_o[ST_CMD]); // R1
    AST_CFG0_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mb_ok(cfg_i[3:0]) |=> sts_o[0]); // R2
    AST_CFG1_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mb_ok(cfg_i[7:4]) |=> sts_o[1]); // R2
    AST_CFG2_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mb_ok(cfg_i[11:8]) |=> sts_o[2]); // R2
    AST_FLAG_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && (code == 4'd1 || code == 4'd2) && !mb_ok(flag)) |=> sts_o[ST_FLAG]); // R3
    AST_ALERT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o == (sts_o != '0)); // R5
    AST_ZERO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_we_i && sts_wdata_i == '0 && !cmd_vld_i && !out_vld_i && cfg_all_ok) |=> sts_o == '0); // R6
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sts_we_i |=> ((sts_o & $past(sts_o)) == $past(sts_o))); // R7
endmodule

bind drbg_cmd_guard drbg_cmd_guard_chk u_chk (.*);

// File: tb/drbg_cmd_guard_test.sv
module drbg_cmd_guard_test;
    import drbg_guard_pkg::*;

    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_vld = 1'b0;
    logic [HDR_W-1:0] cmd_hdr = '0;
    logic [11:0] cfg = 12'h969;
    logic out_vld = 1'b0;
    logic [DATA_W-1:0] out_data = '0;
    logic sts_we = 1'b0;
    logic [STS_W-1:0] sts_wdata = '0;
    logic [STS_W-1:0] sts;
    logic alert;

    int errs = 0;
    int total = 0;

    always #10 clk = ~clk;

    drbg_cmd_guard #(.DATA_W(DATA_W)) uut (
        .clk_i (clk), .rst_ni (rst_n),
        .cmd_vld_i (cmd_vld), .cmd_hdr_i (cmd_hdr), .cfg_i (cfg),
        .out_vld_i (out_vld), .out_data_i (out_data),
        .sts_we_i (sts_we), .sts_wdata_i (sts_wdata),
        .sts_o (sts), .alert_o (alert)
    );

    function automatic logic mb_ok(logic [3:0] v);
        return v == 4'h6 || v == 4'h9;
    endfunction

    task automatic chk(string req, logic [STS_W-1:0] act, logic [STS_W-1:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_alert(string req, logic exp);
        total++;
        if (alert !== exp) begin
            errs++;
            $display("FAIL %s alert actual=%b expected=%b", req, alert, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic write_sts(logic [STS_W-1:0] w);
        @(negedge clk); sts_we = 1'b1; sts_wdata = w;
        @(negedge clk); sts_we = 1'b0;
    endtask

    task automatic send_cmd(logic [3:0] code, logic [3:0] flag);
        @(negedge clk);
        cmd_vld = 1'b1;
        cmd_hdr = {13'h0A5, flag, 4'hC, code};
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    task automatic send_word(logic [DATA_W-1:0] d);
        @(negedge clk); out_vld = 1'b1; out_data = d;
        @(negedge clk); out_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        logic [STS_W-1:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset status", sts, '0);
        chk_alert("R9 reset alert", 1'b0);

        // R1 / R3 sweep over every code and flag value
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                write_sts('0);
                send_cmd(4'(c), 4'(f));
                exp = '0;
                if (c == 0 || c > 5) exp[ST_CMD] = 1'b1;
                if ((c == 1 || c == 2) && !mb_ok(4'(f))) exp[ST_FLAG] = 1'b1;
                chk($sformatf("R1_R3 code=%0d flag=%0d", c, f), sts, exp);
                chk_alert("R5 alert follows status", exp != '0);
            end
        end

        // R2 sweep over each configuration field
        for (int k = 0; k < 3; k++) begin
            for (int v = 0; v < 16; v++) begin
                write_sts('0);
                @(negedge clk);
                cfg = 12'h999;
                cfg[k*4 +: 4] = 4'(v);
                @(negedge clk);
                exp = '0;
                if (!mb_ok(4'(v))) exp[k] = 1'b1;
                chk($sformatf("R2 field=%0d value=%0d", k, v), sts, exp);
                cfg = 12'h969;
            end
        end
        write_sts('0);
        chk("R6 zero write clears", sts, '0);
        chk_alert("R5 alert low when clear", 1'b0);

        // R4 repeated output word
        do_reset();
        send_word(32'h0);
        chk("R4 first word after reset not compared", sts, '0);
        send_word(32'h5);
        chk("R4 distinct word", sts, '0);
        send_word(32'h5);
        chk("R4 repeated word", sts, 6'h20);
        write_sts('0);
        send_word(32'h3);
        @(negedge clk); out_data = 32'h9;
        @(negedge clk);
        send_word(32'h9);
        chk("R4 word without valid ignored", sts, '0);
        for (int i = 1; i < 17; i++) begin
            send_word(32'(i * 32'h1111));
        end
        chk("R4 distinct sequence", sts, '0);
        send_word(32'h1111 * 16);
        chk("R4 repeat after sequence", sts, 6'h20);
        write_sts('0);

        // R7 sticky
        send_cmd(4'h0, 4'h6);
        repeat (5) @(negedge clk);
        chk("R7 bit stays after fault ends", sts, 6'h10);
        chk_alert("R5 alert with sticky bit", 1'b1);

        // R6 partial clear
        send_word(32'h77);
        send_word(32'h77);
        chk("R6 two bits set", sts, 6'h30);
        write_sts(6'h20);
        chk("R6 mask keeps bit 5 only", sts, 6'h20);
        write_sts(6'h00);
        chk("R6 all zero clears", sts, '0);
        chk_alert("R5 alert drops", 1'b0);

        // R8 set wins over clear
        @(negedge clk);
        sts_we = 1'b1; sts_wdata = '0;
        cmd_vld = 1'b1; cmd_hdr = {13'h0, 4'h9, 4'h0, 4'hF};
        @(negedge clk);
        sts_we = 1'b0; cmd_vld = 1'b0;
        chk("R8 set beats clear", sts, 6'h10);

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule